// File: doc/BRIEF.md
# Event Combiner with Masked Flags

This block collects up to 128 single-cycle event pulses into sticky flag bits, split into four groups of 32. Each flag stays set until software clears it. Software can also set flags on its own. Each bit has an event mask, and a group's unmasked pending flags are ORed into one level interrupt line per group. A second mask, independent of the first, screens the same flags into a masked exception view. All bits of that view are ORed into a single exception line.

Software reaches the state through a 32-bit register port addressed in words. Writes take effect in one cycle, and a read returns the addressed word on the following cycle. The register layout has eight regions of eight words each. In every region only the first four words, one per group, hold data. The group count and group width are parameters.

Top module: `event_combiner`

## Requirements
- R1: After reset every flag is 0, every event-mask and exception-mask bit is 1, and `grp_irq` and `exc_irq` are low.
- R2: An event pulse on `evt_in[32*g+b]` sets flag bit b of group g at the next clock edge. A flag stays set until a clear write removes it.
- R3: A write to set word g (word address 8+g, byte offset 0x20+4g) sets every flag bit of group g whose data bit is 1. Zero data bits change nothing.
- R4: A write to clear word g (word address 16+g, byte offset 0x40+4g) clears every flag bit of group g whose data bit is 1. Zero data bits change nothing.
- R5: If an event pulse and a clear write hit the same flag bit in the same cycle, the flag ends up set.
- R6: `grp_irq[g]` is the OR of group g's flags ANDed with the inverse of its event mask. It is registered, so it follows the state one cycle later. A mask bit of 1 blocks that bit.
- R7: Event-mask word g (word address 32+g, byte 0x80+4g) is read/write and holds the mask. Masked-flag word g (word address 40+g, byte 0xA0+4g) reads as the flags AND NOT the event mask.
- R8: Exception-mask word g (word address 48+g, byte 0xC0+4g) is read/write. Masked-exception word g (word address 56+g, byte 0xE0+4g) reads as the flags AND NOT the exception mask. `exc_irq` is the registered OR of all masked-exception bits across the groups.
- R9: Flag word g (word address g, byte 0x00+4g) is read-only and reads the flags. Writes to the flag words and to the two masked views change no state.
- R10: Words 4 to 7 of every region, all of region 3 (byte 0x60 to 0x7F), and the set and clear words all read as 0. Writes to words 4 to 7 and to region 3 change no state.
- R11: `reg_rdata` shows the word addressed by `reg_waddr` one clock edge after that address was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 128 | Event pulses, bit 32*g+b belongs to group g bit b |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 6 | Word address (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| grp_irq | output | 4 | Combined level interrupt per group |
| exc_irq | output | 1 | Combined exception line |

## Verification
The assertions check several rules on every cycle:
- flags are sticky when no clear write is present;
- an event or a set write always leaves its bits set;
- a clear write with no competing event leaves its bits at zero;
- each combined line matches the masked state of the cycle before;
- unused words read as zero.

Other behaviours can only be shown by the bench's scenarios. These are the reset values, the exact address decode of every region, ignored writes to read-only and reserved words, and a sweep of all 128 event bits through a reference model.

// File: rtl/ec_pkg.sv
package ec_pkg;
  // Region selected by word address bits [5:3]; the byte layout is software visible.
  typedef enum logic [2:0] {
    RG_PEND   = 3'd0,
    RG_RAISE  = 3'd1,
    RG_DROP   = 3'd2,
    RG_RSVD   = 3'd3,
    RG_BLOCK  = 3'd4,
    RG_VIEW   = 3'd5,
    RG_XBLOCK = 3'd6,
    RG_XVIEW  = 3'd7
  } region_e;
endpackage

// File: rtl/ec_group.sv
module ec_group #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GROUP_W-1:0] evt,
  input  logic               raise_we,
  input  logic               drop_we,
  input  logic               block_we,
  input  logic               xblock_we,
  input  logic [GROUP_W-1:0] wdata,
  output logic [GROUP_W-1:0] pend,
  output logic [GROUP_W-1:0] block,
  output logic [GROUP_W-1:0] xblock,
  output logic               irq,
  output logic               xhit
);
  logic [GROUP_W-1:0] set_bits, clr_bits;

  assign set_bits = raise_we ? wdata : '0;
  assign clr_bits = drop_we  ? wdata : '0;
  assign xhit     = |(pend & ~xblock);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      block  <= '1;
      xblock <= '1;
      irq    <= 1'b0;
    end else begin
      // new events and set writes override a simultaneous clear
      pend <= (pend & ~clr_bits) | set_bits | evt;
      if (block_we)  block  <= wdata;
      if (xblock_we) xblock <= wdata;
      irq <= |(pend & ~block);
    end
  end

  // R2: without a clear write no flag ever drops
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !drop_we |=> ((pend & $past(pend)) == $past(pend)));
  // R5: every pulsed bit is set afterwards, even with a clear present
  a_r5_evt_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(evt)) == $past(evt)));
  // R3: set write lands
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    raise_we |=> ((pend & $past(wdata)) == $past(wdata)));
  // R4: clear write removes bits that no event or set competes for
  a_r4_clear: assert property (@(posedge clk) disable iff (rst)
    (drop_we && !raise_we) |=> ((pend & $past(wdata & ~evt)) == '0));
  // R6: combined line follows masked state of previous cycle
  a_r6_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(pend & ~block))));
endmodule

// File: rtl/ec_rdmux.sv
module ec_rdmux #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32
) (
  input  logic [5:0]                             waddr,
  input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]     pend,
  input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]     block,
  input  logic [NUM_GROUPS-1:0][GROUP_W-1:0]     xblock,
  output logic [31:0]                            word
);
  import ec_pkg::*;
  region_e            region;
  logic [2:0]         idx;
  logic [GROUP_W-1:0] sel;

  assign region = region_e'(waddr[5:3]);
  assign idx    = waddr[2:0];

  always_comb begin
    sel = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(idx) == g) begin
        case (region)
          RG_PEND:   sel = pend[g];
          RG_BLOCK:  sel = block[g];
          RG_VIEW:   sel = pend[g] & ~block[g];
          RG_XBLOCK: sel = xblock[g];
          RG_XVIEW:  sel = pend[g] & ~xblock[g];
          default:   sel = '0;
        endcase
      end
    end
    word = '0;
    word[GROUP_W-1:0] = sel;
  end
endmodule

// File: rtl/event_combiner.sv
module event_combiner #(
  parameter int NUM_GROUPS = 4,
  parameter int GROUP_W    = 32,
  localparam int NUM_EVT   = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVT-1:0]    evt_in,
  input  logic                  reg_we,
  input  logic [5:0]            reg_waddr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic [NUM_GROUPS-1:0] grp_irq,
  output logic                  exc_irq
);
  import ec_pkg::*;

  region_e                          wr_region;
  logic [2:0]                       wr_idx;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] pend_a, block_a, xblock_a;
  logic [NUM_GROUPS-1:0]            xhit_a;
  logic [31:0]                      rd_word;

  assign wr_region = region_e'(reg_waddr[5:3]);
  assign wr_idx    = reg_waddr[2:0];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_we && (int'(wr_idx) == g);
    ec_group #(.GROUP_W(GROUP_W)) u_grp (
      .clk       (clk),
      .rst       (rst),
      .evt       (evt_in[g*GROUP_W +: GROUP_W]),
      .raise_we  (hit && wr_region == RG_RAISE),
      .drop_we   (hit && wr_region == RG_DROP),
      .block_we  (hit && wr_region == RG_BLOCK),
      .xblock_we (hit && wr_region == RG_XBLOCK),
      .wdata     (reg_wdata[GROUP_W-1:0]),
      .pend      (pend_a[g]),
      .block     (block_a[g]),
      .xblock    (xblock_a[g]),
      .irq       (grp_irq[g]),
      .xhit      (xhit_a[g])
    );
  end

  ec_rdmux #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_rd (
    .waddr  (reg_waddr),
    .pend   (pend_a),
    .block  (block_a),
    .xblock (xblock_a),
    .word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      exc_irq   <= 1'b0;
    end else begin
      reg_rdata <= rd_word;
      exc_irq   <= |xhit_a;
    end
  end

  // R8: exception line is the registered OR over all groups
  a_r8_exc_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (exc_irq == $past(|xhit_a)));
  // R10: words beyond the group count always read zero
  a_r10_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (int'(reg_waddr[2:0]) >= NUM_GROUPS) |=> (reg_rdata == '0));
endmodule

// File: tb/event_combiner_tb.sv
module event_combiner_tb;
  localparam int G = 4;
  localparam int W = 32;
  localparam int N = G * W;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  evt_in;
  logic          reg_we;
  logic [5:0]    reg_waddr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic [G-1:0]  grp_irq;
  logic          exc_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_pend [G];
  logic [31:0] m_blk  [G];
  logic [31:0] m_xblk [G];

  always #5 clk = ~clk;

  event_combiner u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_irq(grp_irq), .exc_irq(exc_irq)
  );

  task automatic chk(input string r, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    int rg = int'(a[5:3]);
    int w  = int'(a[2:0]);
    if (w >= G) return 32'h0;
    case (rg)
      0: return m_pend[w];
      4: return m_blk[w];
      5: return m_pend[w] & ~m_blk[w];
      6: return m_xblk[w];
      7: return m_pend[w] & ~m_xblk[w];
      default: return 32'h0;
    endcase
  endfunction

  // one cycle of stimulus; the model is updated from the requirements
  task automatic op(input bit we, input logic [5:0] a, input logic [31:0] d, input logic [N-1:0] e);
    int rg = int'(a[5:3]);
    int w  = int'(a[2:0]);
    @(negedge clk);
    reg_we = we; reg_waddr = a; reg_wdata = d; evt_in = e;
    @(posedge clk);
    for (int g = 0; g < G; g++) begin
      logic [31:0] s = 32'h0;
      logic [31:0] c = 32'h0;
      if (we && w == g && rg == 1) s = d;
      if (we && w == g && rg == 2) c = d;
      m_pend[g] = (m_pend[g] & ~c) | s | e[g*W +: W];
      if (we && w == g && rg == 4) m_blk[g]  = d;
      if (we && w == g && rg == 6) m_xblk[g] = d;
    end
    @(negedge clk);
    reg_we = 1'b0; evt_in = '0;
  endtask

  task automatic chk_out(input string r);
    logic x = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < G; g++) begin
      chk(r, $sformatf("grp_irq[%0d]", g), {31'h0, grp_irq[g]}, {31'h0, |(m_pend[g] & ~m_blk[g])});
      x |= |(m_pend[g] & ~m_xblk[g]);
    end
    chk(r, "exc_irq", {31'h0, exc_irq}, {31'h0, x});
  endtask

  task automatic rd_chk(input string r, input logic [5:0] a);
    @(negedge clk);
    reg_waddr = a;
    @(posedge clk);
    #1;
    chk(r, $sformatf("word %0d", a), reg_rdata, exp_rd(a));
  endtask

  task automatic chk_all(input string r);
    chk_out(r);
    for (int a = 0; a < 64; a++) rd_chk(r, 6'(a));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] one;
    rst = 1'b1; evt_in = '0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0;
    for (int g = 0; g < G; g++) begin
      m_pend[g] = 32'h0; m_blk[g] = 32'hFFFF_FFFF; m_xblk[g] = 32'hFFFF_FFFF;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    chk_all("R1");   // reset state, also covers R11 decode

    // R6: all masked, an event must not raise any line
    op(1'b0, 6'd0, 32'h0, {{(N-1){1'b0}}, 1'b1});
    chk_all("R6");
    op(1'b1, 6'd16, 32'h1, '0);

    // unmask everything, then walk every event bit
    for (int g = 0; g < G; g++) op(1'b1, 6'(32 + g), 32'h0, '0);
    for (int i = 0; i < N; i++) begin
      one = '0; one[i] = 1'b1;
      op(1'b0, 6'd0, 32'h0, one);
      chk_out("R6");
      rd_chk("R2", 6'(i / W));
      rd_chk("R7", 6'(40 + i / W));
      op(1'b1, 6'(16 + i / W), 32'h1 << (i % W), '0);
      chk_out("R4");
    end

    // R3: set writes, including an all-zero write
    for (int g = 0; g < G; g++) begin
      op(1'b1, 6'(8 + g), 32'hA5C3_0F01 ^ (32'h1111_1111 * g), '0);
      op(1'b1, 6'(8 + g), 32'h0, '0);
    end
    chk_all("R3");

    // R4: partial clears and a zero clear
    for (int g = 0; g < G; g++) begin
      op(1'b1, 6'(16 + g), 32'h0000_FFFF << g, '0);
      op(1'b1, 6'(16 + g), 32'h0, '0);
    end
    chk_all("R4");

    // R5: event and clear of the same bit together
    for (int g = 0; g < G; g++) begin
      op(1'b1, 6'(8 + g), 32'hFFFF_FFFF, '0);
      one = '0; one[g*W + 3 + g] = 1'b1;
      op(1'b1, 6'(16 + g), 32'hFFFF_FFFF, one);
      rd_chk("R5", 6'(g));
    end
    chk_out("R5");

    // R7: event-mask sweep with pending flags present
    for (int g = 0; g < G; g++) op(1'b1, 6'(8 + g), 32'h8000_0001 << g, '0);
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < G; g++)
        op(1'b1, 6'(32 + g), (p == g) ? 32'h0 : 32'hFFFF_FFFF ^ (32'h1 << (p * 7)), '0);
      chk_all("R7");
    end

    // R8: exception mask picks one group at a time, then none
    for (int p = 0; p < G; p++) begin
      for (int g = 0; g < G; g++)
        op(1'b1, 6'(48 + g), (p == g) ? 32'h7FFF_FFFE : 32'hFFFF_FFFF, '0);
      chk_all("R8");
    end
    for (int g = 0; g < G; g++) op(1'b1, 6'(48 + g), 32'hFFFF_FFFF, '0);
    chk_all("R8");

    // R9: writes to flag words and the masked views change nothing
    for (int g = 0; g < G; g++) begin
      op(1'b1, 6'(g), 32'hFFFF_FFFF, '0);
      op(1'b1, 6'(40 + g), 32'hFFFF_FFFF, '0);
      op(1'b1, 6'(56 + g), 32'h0, '0);
    end
    chk_all("R9");

    // R10: reserved region and unused words
    for (int w = 0; w < 8; w++) op(1'b1, 6'(24 + w), 32'hFFFF_FFFF, '0);
    for (int w = G; w < 8; w++) begin
      op(1'b1, 6'(8 + w), 32'hFFFF_FFFF, '0);
      op(1'b1, 6'(16 + w), 32'hFFFF_FFFF, '0);
      op(1'b1, 6'(32 + w), 32'h0, '0);
      op(1'b1, 6'(48 + w), 32'h0, '0);
    end
    chk_all("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule